// File: doc/BRIEF.md
# Condition-Field Mask-Match Unit

This execution unit evaluates one mask-and-pattern test on condition-register state in a single clock. The condition register is 32 bits wide and holds eight 4-bit fields. Each operation takes a 4-bit source: either one field of that register, or the least significant bit of an integer operand copied into all four positions. Every source bit is compared with the matching bit of a 4-bit expected pattern (`pat_i`), and the comparison only counts where the 4-bit `mask_i` is set. The four match bits are then used in one of two ways. They are written as a whole field, or they are reduced to one bit by OR (when `any_i` is 1) or by AND (when `any_i` is 0). That one bit goes either to the integer result or to one addressed condition bit.

Two selector bits choose which source and destination are paired. The unit returns an integer result with its enable, and a merged condition-register image with a per-bit write mask. All outputs are registered. The register file around the unit applies these writes.

Top module: `crmm_unit`

## Requirements
- R1: Field bit k (k=0..3) of field f is `cr_i[4f+3-k]`, so field 0 sits in `cr_i[3:0]` with bit k=0 at `cr_i[3]`. `mask_i[k]` and `pat_i[k]` pair with field bit k. Match bit k is `mask_i[k] & (pat_i[k] == src_k)`.
- R2: With `{sel_hi_i,sel_lo_i}=00`, the source is field `src_fld_i`. The result is the OR of the match bits when `any_i`=1 and their AND when `any_i`=0. It lands in `int_res_o[0]`, `int_res_o[63:1]` is zero, `int_we_o`=1 and `cr_we_o`=0.
- R3: With `{sel_hi_i,sel_lo_i}=01`, every src_k equals `int_op_i[0]`. The four match bits are written to field `src_fld_i` with a 4-bit enable.
- R4: When `int_zero_i`=1, the integer operand is taken as zero whatever `int_op_i` holds.
- R5: With `{sel_hi_i,sel_lo_i}=10`, the match bits of field `src_fld_i` are written to field `tgt_i[2:0]`. `tgt_i[4:3]` has no effect.
- R6: With `{sel_hi_i,sel_lo_i}=11`, the R2 reduction is written only to `cr_i[4*tgt_i[2:0]+3-tgt_i[4:3]]`. `cr_we_o` is one-hot.
- R7: `cr_wdata_o` equals `cr_i` outside the bits set in `cr_we_o`.
- R8: At most one of the integer and condition write paths is enabled. A cycle without `issue_i` gives no enable on the next cycle.
- R9: While `rst` is high, all outputs are zero on the following edge.
- R10: With a zero integer operand, mask m and pattern 0000 set the masked bits of the target field and clear the rest. Pattern 1111 writes all zeros. Mask 1111 with pattern ~p loads the field with p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Operation valid this cycle |
| sel_lo_i | input | 1 | Selector bit: integer side / single-bit target |
| sel_hi_i | input | 1 | Selector bit: condition-to-condition |
| mask_i | input | 4 | Compare mask, index k = field bit k |
| pat_i | input | 4 | Expected-value pattern |
| any_i | input | 1 | 1 = OR reduction, 0 = AND reduction |
| src_fld_i | input | 3 | Source field (also target for integer-to-field) |
| tgt_i | input | 5 | [2:0] target field, [4:3] bit in field |
| int_zero_i | input | 1 | Treat integer operand as zero |
| int_op_i | input | 64 | Integer operand |
| cr_i | input | 32 | Current condition register |
| int_res_o | output | 64 | Integer result |
| int_we_o | output | 1 | Integer write enable |
| cr_wdata_o | output | 32 | Merged condition register image |
| cr_we_o | output | 32 | Per-bit condition write enable |

## Verification
Every result is due on the first rising edge after the edge that samples `issue_i`. The bench therefore changes inputs on a falling edge and compares all four outputs on the next falling edge, one full cycle later. Ops are issued back to back, so each sample also shows that a result does not spill into the next cycle. The idle and reset checks look one edge after `issue_i` falls or `rst` rises.

// File: rtl/crmm_pkg.sv
package crmm_pkg;
  typedef enum logic [1:0] {
    OP_FLD2INT = 2'b00,
    OP_INT2FLD = 2'b01,
    OP_FLD2FLD = 2'b10,
    OP_FLD2BIT = 2'b11
  } crmm_op_e;
endpackage

// File: rtl/crmm_field_pick.sv
module crmm_field_pick #(
  parameter int NF = 8,
  parameter int FW = 4,
  localparam int CRW = NF * FW,
  localparam int FSW = $clog2(NF)
) (
  input  logic [CRW-1:0] cr_i,
  input  logic [FSW-1:0] sel_i,
  output logic [FW-1:0]  fld_o
);
  logic [FW-1:0] fields [NF];

  for (genvar f = 0; f < NF; f++) begin : g_fld
    for (genvar k = 0; k < FW; k++) begin : g_bit
      assign fields[f][k] = cr_i[FW*f + FW-1-k];
    end
  end

  assign fld_o = fields[sel_i];
endmodule

// File: rtl/crmm_match.sv
module crmm_match #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] src_i,
  input  logic [FW-1:0] mask_i,
  input  logic [FW-1:0] pat_i,
  input  logic          any_i,
  output logic [FW-1:0] hit_o,
  output logic          red_o
);
  for (genvar k = 0; k < FW; k++) begin : g_cmp
    assign hit_o[k] = mask_i[k] & ~(pat_i[k] ^ src_i[k]);
  end

  assign red_o = any_i ? (|hit_o) : (&hit_o);
endmodule

// File: rtl/crmm_merge.sv
module crmm_merge #(
  parameter int NF = 8,
  parameter int FW = 4,
  localparam int CRW = NF * FW,
  localparam int FSW = $clog2(NF),
  localparam int BSW = $clog2(FW)
) (
  input  logic [CRW-1:0] cr_i,
  input  logic           fld_en_i,
  input  logic           bit_en_i,
  input  logic [FSW-1:0] fld_i,
  input  logic [BSW-1:0] bit_i,
  input  logic [FW-1:0]  hit_i,
  input  logic           red_i,
  output logic [CRW-1:0] data_o,
  output logic [CRW-1:0] we_o
);
  logic [CRW-1:0] fld_we, bit_we, fld_val, bit_val;

  for (genvar f = 0; f < NF; f++) begin : g_f
    for (genvar k = 0; k < FW; k++) begin : g_k
      assign fld_we[FW*f + FW-1-k]  = fld_en_i && (fld_i == FSW'(f));
      assign bit_we[FW*f + FW-1-k]  = bit_en_i && (fld_i == FSW'(f)) && (bit_i == BSW'(k));
      assign fld_val[FW*f + FW-1-k] = hit_i[k];
      assign bit_val[FW*f + FW-1-k] = red_i;
    end
  end

  always_comb begin
    we_o   = fld_we | bit_we;
    data_o = (cr_i & ~we_o) | (fld_we & fld_val) | (bit_we & bit_val);
  end
endmodule

// File: rtl/crmm_unit.sv
module crmm_unit #(
  parameter int XLEN = 64,
  parameter int NF   = 8,
  parameter int FW   = 4,
  localparam int CRW = NF * FW,
  localparam int FSW = $clog2(NF),
  localparam int BSW = $clog2(FW),
  localparam int TW  = FSW + BSW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  logic            sel_lo_i,
  input  logic            sel_hi_i,
  input  logic [FW-1:0]   mask_i,
  input  logic [FW-1:0]   pat_i,
  input  logic            any_i,
  input  logic [FSW-1:0]  src_fld_i,
  input  logic [TW-1:0]   tgt_i,
  input  logic            int_zero_i,
  input  logic [XLEN-1:0] int_op_i,
  input  logic [CRW-1:0]  cr_i,
  output logic [XLEN-1:0] int_res_o,
  output logic            int_we_o,
  output logic [CRW-1:0]  cr_wdata_o,
  output logic [CRW-1:0]  cr_we_o
);
  import crmm_pkg::*;

  crmm_op_e       op;
  logic [FW-1:0]  fld_src, src, hit;
  logic           red, int_lsb, fld_en, bit_en;
  logic [FSW-1:0] dst_fld;
  logic [CRW-1:0] mdata, mwe;

  assign op      = crmm_op_e'({sel_hi_i, sel_lo_i});
  assign int_lsb = int_op_i[0] & ~int_zero_i;

  crmm_field_pick #(.NF(NF), .FW(FW)) u_pick (
    .cr_i(cr_i), .sel_i(src_fld_i), .fld_o(fld_src)
  );

  assign src = (op == OP_INT2FLD) ? {FW{int_lsb}} : fld_src;

  crmm_match #(.FW(FW)) u_match (
    .src_i(src), .mask_i(mask_i), .pat_i(pat_i), .any_i(any_i),
    .hit_o(hit), .red_o(red)
  );

  always_comb begin
    fld_en  = issue_i && (op == OP_INT2FLD || op == OP_FLD2FLD);
    bit_en  = issue_i && (op == OP_FLD2BIT);
    dst_fld = (op == OP_INT2FLD) ? src_fld_i : tgt_i[FSW-1:0];
  end

  crmm_merge #(.NF(NF), .FW(FW)) u_merge (
    .cr_i(cr_i), .fld_en_i(fld_en), .bit_en_i(bit_en),
    .fld_i(dst_fld), .bit_i(tgt_i[TW-1:FSW]),
    .hit_i(hit), .red_i(red), .data_o(mdata), .we_o(mwe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_res_o  <= '0;
      int_we_o   <= 1'b0;
      cr_wdata_o <= '0;
      cr_we_o    <= '0;
    end else begin
      int_we_o   <= issue_i && (op == OP_FLD2INT);
      int_res_o  <= {{(XLEN-1){1'b0}}, issue_i && (op == OP_FLD2INT) && red};
      cr_wdata_o <= mdata;
      cr_we_o    <= mwe;
    end
  end
endmodule

// File: rtl/crmm_unit_chk.sv
module crmm_unit_chk #(
  parameter int XLEN = 64,
  parameter int CRW  = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_i,
  input logic [CRW-1:0]  cr_i,
  input logic [XLEN-1:0] int_res_o,
  input logic            int_we_o,
  input logic [CRW-1:0]  cr_wdata_o,
  input logic [CRW-1:0]  cr_we_o
);
  a_r8_one_path: assert property (@(posedge clk) disable iff (rst)
    !(int_we_o && (cr_we_o != '0)));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    int_res_o[XLEN-1:1] == '0);

  a_r6_we_shape: assert property (@(posedge clk) disable iff (rst)
    ($countones(cr_we_o) == 0) || ($countones(cr_we_o) == 1) || ($countones(cr_we_o) == 4));

  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> (!int_we_o && cr_we_o == '0));

  a_r7_keep: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> (((cr_wdata_o ^ $past(cr_i)) & ~cr_we_o) == '0));

  a_r9_reset: assert property (@(posedge clk)
    rst |=> (!int_we_o && cr_we_o == '0 && int_res_o == '0 && cr_wdata_o == '0));
endmodule

bind crmm_unit crmm_unit_chk #(.XLEN(XLEN), .CRW(CRW)) u_chk (
  .clk(clk), .rst(rst), .issue_i(issue_i), .cr_i(cr_i),
  .int_res_o(int_res_o), .int_we_o(int_we_o),
  .cr_wdata_o(cr_wdata_o), .cr_we_o(cr_we_o)
);

// File: tb/crmm_unit_tb.sv
module crmm_unit_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        issue = 0, sel_lo = 0, sel_hi = 0, any = 0, izero = 0;
  logic [3:0]  mask = 0, pat = 0;
  logic [2:0]  sfld = 0;
  logic [4:0]  tgt = 0;
  logic [63:0] iop = 0;
  logic [31:0] cr = 0;
  logic [63:0] int_res;
  logic        int_we;
  logic [31:0] cr_wdata, cr_we;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  crmm_unit u_dut (
    .clk(clk), .rst(rst), .issue_i(issue), .sel_lo_i(sel_lo), .sel_hi_i(sel_hi),
    .mask_i(mask), .pat_i(pat), .any_i(any), .src_fld_i(sfld), .tgt_i(tgt),
    .int_zero_i(izero), .int_op_i(iop), .cr_i(cr),
    .int_res_o(int_res), .int_we_o(int_we), .cr_wdata_o(cr_wdata), .cr_we_o(cr_we)
  );

  logic [63:0] e_int;
  logic        e_iwe;
  logic [31:0] e_cd, e_cwe;

  task automatic model();
    logic [3:0] s, n;
    logic r;
    int op, pos;
    op = {sel_hi, sel_lo};
    for (int k = 0; k < 4; k++) begin
      s[k] = (op == 1) ? (iop[0] && !izero) : cr[4*sfld + 3 - k];
      n[k] = mask[k] && (pat[k] == s[k]);
    end
    r = any ? (n != 0) : (n == 4'hF);
    e_int = 0; e_iwe = 0; e_cd = cr; e_cwe = 0;
    if (!issue) return;
    if (op == 0) begin e_int = {63'd0, r}; e_iwe = 1; end
    else if (op == 3) begin
      pos = 4*tgt[2:0] + 3 - tgt[4:3];
      e_cwe[pos] = 1; e_cd[pos] = r;
    end else begin
      for (int k = 0; k < 4; k++) begin
        pos = 4*((op == 1) ? sfld : tgt[2:0]) + 3 - k;
        e_cwe[pos] = 1; e_cd[pos] = n[k];
      end
    end
  endtask

  task automatic check(input string req);
    total++;
    if (int_res !== e_int || int_we !== e_iwe || cr_wdata !== e_cd || cr_we !== e_cwe) begin
      bad++;
      $display("FAIL %s op=%0d: got res=%h iwe=%b cd=%h cwe=%h exp res=%h iwe=%b cd=%h cwe=%h",
               req, {sel_hi, sel_lo}, int_res, int_we, cr_wdata, cr_we, e_int, e_iwe, e_cd, e_cwe);
    end
  endtask

  task automatic step(input string req);
    model();
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic expect_field(input string req, input int f, input logic [3:0] v);
    logic [3:0] got;
    for (int k = 0; k < 4; k++) got[k] = cr_wdata[4*f + 3 - k];
    total++;
    if (got !== v || cr_we[4*f +: 4] !== 4'hF) begin
      bad++;
      $display("FAIL %s field=%h we=%h exp field=%h we=f", req, got, cr_we[4*f +: 4], v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R8 watchdog expired: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state, inputs nonzero and issued
    cr = 32'hFFFF_FFFF; issue = 1; mask = 4'hF; sel_lo = 1;
    @(negedge clk); @(negedge clk);
    e_int = 0; e_iwe = 0; e_cd = 0; e_cwe = 0; check("R9");
    rst = 0; issue = 0;
    // R8: idle cycle gives no enables
    step("R8");

    // Exhaustive sweep over op, mask, pattern, reduction, field: R1 R2 R3 R4 R5 R6 R7 R8
    issue = 1;
    for (int op = 0; op < 4; op++)
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 16; p++)
          for (int a = 0; a < 2; a++)
            for (int f = 0; f < 8; f++) begin
              seed = seed * 32'd1664525 + 32'd1013904223;
              cr = seed; iop = {seed, ~seed};
              {sel_hi, sel_lo} = 2'(op); mask = 4'(m); pat = 4'(p); any = a[0];
              sfld = 3'(f); izero = seed[7];
              tgt = {seed[12:11], 3'(7 - f)};
              case (op)
                0: step("R2/R1");
                1: step(izero ? "R4/R3" : "R3/R1");
                2: step("R5/R7");
                default: step("R6/R7");
              endcase
            end

    // R1 layout: field 0 in cr[3:0], field bit 0 at cr[3]
    {sel_hi, sel_lo} = 2'b00; cr = 32'h0000_0008; mask = 4'b0001; pat = 4'b0001; any = 1;
    sfld = 0; step("R1"); if (int_res[0] !== 1'b1) begin bad++; $display("FAIL R1 got=%b exp=1", int_res[0]); end
    total++;
    sfld = 7; step("R1");

    // R10 idioms, zero operand with garbage int_op
    {sel_hi, sel_lo} = 2'b01; izero = 1; iop = '1; cr = 32'hA5A5_A5A5; sfld = 3;
    mask = 4'b0110; pat = 4'b0000; step("R10"); expect_field("R10 set", 3, 4'b0110);
    pat = 4'b1111; step("R10"); expect_field("R10 clear", 3, 4'b0000);
    mask = 4'b1111; pat = ~4'b1011; step("R10"); expect_field("R10 load", 3, 4'b1011);

    // R5: tgt[4:3] has no effect on field copy
    {sel_hi, sel_lo} = 2'b10; izero = 0; cr = 32'h1234_5678; sfld = 2; mask = 4'hF; pat = 4'h5;
    tgt = 5'b11_110; step("R5");
    tgt = 5'b00_110; step("R5");

    // R8: issue dropped
    issue = 0; step("R8");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule